// File: doc/BRIEF.md
# Single-Comparator PFM Phase Sequencer

This block is the digital sequencer of a pulse-frequency-modulated buck converter whose analog front end has one comparator. The comparator is shared by three sensing phases. Each rising edge of its decision ends the current phase. In the regulation phase the comparator looks at reference against feedback. In the high-side phase it looks at the amplified switch-node voltage against a programmable peak threshold. In the freewheel phase it looks for the zero-current point. The sequencer keeps a two-bit state (A,B) and decodes it into three one-hot select lines, which route the right signal pair into the comparator.

The block drives the high-side and low-side power switch enables. A programmable dead time separates every handover, and the two enables are never high together. It holds the peak-current trim code that an external level shifter uses. Code 0000 gives the smallest peak current and code 1111 the largest. The time spent in the high-side phase sets the peak inductor current. A timeout pulls a stuck high-side or freewheel phase back to idle with both switches off and raises a fault flag.

Top module: `pfm_phase_seq`

## Requirements
- R1: While `rstN` is low and right after reset: `phaseAB` is 2'b00, `sel` is 3'b001, `hsEn` and `lsEn` are 0, `fault` is 0 and `trimCode` is 0.
- R2: `sel` is always one-hot and follows `phaseAB`. State 2'b00 (idle, regulation check) gives bit0. State 2'b10 (A=1, B=0, on-time) gives bit1. State 2'b11 (A=1, B=1, freewheel) gives bit2.
- R3: Each rising edge of `cmpDecision` moves the state 00→10→11→00. The new state is visible after the third rising clock edge that follows the input change. A `cmpDecision` held high advances the state only once.
- R4: `hsEn` goes high only in state 10 and `lsEn` only in state 11. Each enable drops one cycle after its state is left, and the two are never high together.
- R5: After either enable drops, both stay low for exactly `deadCfg` cycles before the other one may rise. A `deadCfg` of 0 acts as 1.
- R6: If state 10 or 11 lasts `tmoCfg` clock cycles with no comparator edge, the state returns to 00 and `fault` is set. A comparator edge in the same cycle takes priority. A `tmoCfg` of 0 disables the timeout.
- R7: `fault` stays set through idle and clears when the next comparator edge starts a new on-time.
- R8: `trimLoad` copies `trimIn` into `trimCode` only while the state is 00. In any other state the load is ignored and `trimCode` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpDecision | input | 1 | Asynchronous comparator output |
| deadCfg | input | DEAD_W | Dead-time length in cycles (0 acts as 1) |
| tmoCfg | input | TMO_W | Maximum phase length in cycles (0 disables) |
| trimIn | input | TRIM_W | New peak-current trim code |
| trimLoad | input | 1 | Load strobe for `trimIn` |
| phaseAB | output | 2 | State bits {A,B} |
| sel | output | 3 | One-hot comparator routing selects {S3,S2,S1} |
| hsEn | output | 1 | High-side switch enable |
| lsEn | output | 1 | Low-side switch enable |
| trimCode | output | TRIM_W | Held trim code for the level shifter |
| fault | output | 1 | Phase timeout flag |

## Verification
The bench builds the block with TRIM_W=4, DEAD_W=4 and TMO_W=8. With an 8-bit timeout, a 20-cycle limit can end both the on-time and the freewheel phase within a few dozen cycles. The disabled setting can then be held for several hundred cycles to show that it never trips. A 4-bit dead-time field covers both the zero-to-one substitution and a multi-cycle gap, so each handover edge can be checked cycle by cycle against the three-cycle comparator latency.

// File: rtl/pfm_seq_pkg.sv
package pfm_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_HIGH = 2'b10,
    PH_LOW  = 2'b11
  } phase_e;

  typedef struct packed {
    logic idlePhase;
    logic hsPhase;
    logic lsPhase;
  } seqStb_t;

endpackage

// File: rtl/pfm_seq_ctrl.sv
module pfm_seq_ctrl
  import pfm_seq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic [TMO_W-1:0] tmoCfg,
  output phase_e           phase,
  output seqStb_t          stb,
  output logic             fault
);

  logic [2:0]       syncQ;
  logic             cmpRise;
  logic             tmoHit;
  logic [TMO_W-1:0] phaseCnt;
  phase_e           phaseNxt;

  // two synchroniser stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], cmpIn};
  end

  assign cmpRise = syncQ[1] & ~syncQ[2];
  assign tmoHit  = (phase != PH_IDLE) && (tmoCfg != '0) &&
                   (phaseCnt == tmoCfg - TMO_W'(1));

  always_comb begin
    phaseNxt = phase;
    unique case (phase)
      PH_IDLE: if (cmpRise) phaseNxt = PH_HIGH;
      PH_HIGH: begin
        if (cmpRise)     phaseNxt = PH_LOW;
        else if (tmoHit) phaseNxt = PH_IDLE;
      end
      PH_LOW:  if (cmpRise || tmoHit) phaseNxt = PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      fault    <= 1'b0;
    end else begin
      phase <= phaseNxt;
      if (phaseNxt != phase || phase == PH_IDLE) phaseCnt <= '0;
      else                                       phaseCnt <= phaseCnt + TMO_W'(1);
      if (tmoHit && !cmpRise)               fault <= 1'b1;
      else if (phase == PH_IDLE && cmpRise) fault <= 1'b0;
    end
  end

  always_comb begin
    stb.idlePhase = (phase == PH_IDLE);
    stb.hsPhase   = (phase == PH_HIGH);
    stb.lsPhase   = (phase == PH_LOW);
  end

endmodule

// File: rtl/pfm_seq_dp.sv
module pfm_seq_dp
  import pfm_seq_pkg::*;
#(
  parameter int TRIM_W = 4,
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [DEAD_W-1:0] deadCfg,
  input  logic [TRIM_W-1:0] trimIn,
  input  logic              trimLoad,
  output logic [2:0]        sel,
  output logic              hsEn,
  output logic              lsEn,
  output logic [TRIM_W-1:0] trimCode
);

  logic [DEAD_W-1:0] deadCnt;
  logic [DEAD_W-1:0] deadLoad;
  logic              gapDone;

  assign deadLoad = (deadCfg == '0) ? DEAD_W'(1) : deadCfg;
  assign gapDone  = (deadCnt <= DEAD_W'(1));
  assign sel      = {stb.lsPhase, stb.hsPhase, stb.idlePhase};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsEn    <= 1'b0;
      lsEn    <= 1'b0;
      deadCnt <= '0;
    end else if (hsEn && !stb.hsPhase) begin
      hsEn    <= 1'b0;
      deadCnt <= deadLoad;
    end else if (lsEn && !stb.lsPhase) begin
      lsEn    <= 1'b0;
      deadCnt <= deadLoad;
    end else begin
      if (deadCnt != '0) deadCnt <= deadCnt - DEAD_W'(1);
      if (stb.hsPhase && !hsEn && !lsEn && gapDone) hsEn <= 1'b1;
      if (stb.lsPhase && !lsEn && !hsEn && gapDone) lsEn <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            trimCode <= '0;
    else if (trimLoad && stb.idlePhase)   trimCode <= trimIn;
  end

endmodule

// File: rtl/pfm_phase_seq.sv
module pfm_phase_seq
  import pfm_seq_pkg::*;
#(
  parameter int TRIM_W = 4,
  parameter int DEAD_W = 4,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpDecision,
  input  logic [DEAD_W-1:0] deadCfg,
  input  logic [TMO_W-1:0]  tmoCfg,
  input  logic [TRIM_W-1:0] trimIn,
  input  logic              trimLoad,
  output logic [1:0]        phaseAB,
  output logic [2:0]        sel,
  output logic              hsEn,
  output logic              lsEn,
  output logic [TRIM_W-1:0] trimCode,
  output logic              fault
);

  phase_e  phase;
  seqStb_t stb;

  pfm_seq_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmpIn  (cmpDecision),
    .tmoCfg (tmoCfg),
    .phase  (phase),
    .stb    (stb),
    .fault  (fault)
  );

  pfm_seq_dp #(.TRIM_W(TRIM_W), .DEAD_W(DEAD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .deadCfg  (deadCfg),
    .trimIn   (trimIn),
    .trimLoad (trimLoad),
    .sel      (sel),
    .hsEn     (hsEn),
    .lsEn     (lsEn),
    .trimCode (trimCode)
  );

  assign phaseAB = phase;

endmodule

// File: rtl/pfm_seq_chk.sv
module pfm_seq_chk #(
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phaseAB,
  input logic [2:0]        sel,
  input logic              hsEn,
  input logic              lsEn,
  input logic [TRIM_W-1:0] trimCode,
  input logic              fault
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sel) == 1); // R2

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && lsEn)); // R4

  AST_HS_IN_ONTIME: assert property (@(posedge clk) disable iff (!rstN)
    hsEn |-> $past(phaseAB) == 2'b10); // R4

  AST_LS_IN_FREEWHEEL: assert property (@(posedge clk) disable iff (!rstN)
    lsEn |-> $past(phaseAB) == 2'b11); // R4

  AST_LS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsEn) |-> !$past(hsEn)); // R5

  AST_HS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsEn) |-> !$past(lsEn)); // R5

  AST_FAULT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> phaseAB == 2'b00); // R6

  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phaseAB != 2'b00) |=> $stable(trimCode)); // R8

endmodule

bind pfm_phase_seq pfm_seq_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .phaseAB  (phaseAB),
  .sel      (sel),
  .hsEn     (hsEn),
  .lsEn     (lsEn),
  .trimCode (trimCode),
  .fault    (fault)
);

// File: tb/tb_pfm_phase_seq.sv
module tb_pfm_phase_seq;

  localparam int TRIM_W = 4;
  localparam int DEAD_W = 4;
  localparam int TMO_W  = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmpDecision;
  logic [DEAD_W-1:0] deadCfg;
  logic [TMO_W-1:0]  tmoCfg;
  logic [TRIM_W-1:0] trimIn;
  logic              trimLoad;
  logic [1:0]        phaseAB;
  logic [2:0]        sel;
  logic              hsEn;
  logic              lsEn;
  logic [TRIM_W-1:0] trimCode;
  logic              fault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pfm_phase_seq #(.TRIM_W(TRIM_W), .DEAD_W(DEAD_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rstN(rstN), .cmpDecision(cmpDecision), .deadCfg(deadCfg),
    .tmoCfg(tmoCfg), .trimIn(trimIn), .trimLoad(trimLoad), .phaseAB(phaseAB),
    .sel(sel), .hsEn(hsEn), .lsEn(lsEn), .trimCode(trimCode), .fault(fault)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one comparator edge; returns at the negedge after the state update
  task automatic cmpRise(input logic [1:0] fromSt, input logic [1:0] toSt);
    cmpDecision = 1'b0;
    tick(1);
    cmpDecision = 1'b1;
    tick(2);
    check("R3", "state before third edge", phaseAB, fromSt);
    tick(1);
    check("R3", "state after third edge", phaseAB, toSt);
    cmpDecision = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; cmpDecision = 1'b0; deadCfg = 4'd3; tmoCfg = 8'd200;
    trimIn = '0; trimLoad = 1'b0;
    #2;
    check("R1", "phase in reset", phaseAB, 2'b00);
    check("R1", "sel in reset", sel, 3'b001);
    check("R1", "enables in reset", {hsEn, lsEn}, 2'b00);
    check("R1", "fault in reset", fault, 1'b0);
    check("R1", "trim in reset", trimCode, 4'h0);
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R1", "phase after reset", phaseAB, 2'b00);
    check("R2", "sel idle", sel, 3'b001);
  endtask

  task automatic testTrimIdle();
    trimIn = 4'hA; trimLoad = 1'b1;
    tick(1);
    trimLoad = 1'b0;
    check("R8", "trim loaded in idle", trimCode, 4'hA);
  endtask

  task automatic testFullCycle();
    cmpRise(2'b00, 2'b10);
    check("R4", "hsEn lags state", hsEn, 1'b0);
    tick(1);
    check("R4", "hsEn on in on-time", {hsEn, lsEn}, 2'b10);
    check("R2", "sel on-time", sel, 3'b010);
    trimIn = 4'h5; trimLoad = 1'b1;
    tick(1);
    trimLoad = 1'b0;
    check("R8", "trim load ignored in on-time", trimCode, 4'hA);
    cmpRise(2'b10, 2'b11);
    check("R2", "sel freewheel", sel, 3'b100);
    tick(1);
    check("R5", "both off first gap cycle", {hsEn, lsEn}, 2'b00);
    tick(2);
    check("R5", "both off last gap cycle", {hsEn, lsEn}, 2'b00);
    tick(1);
    check("R5", "lsEn on after 3-cycle gap", {hsEn, lsEn}, 2'b01);
    cmpRise(2'b11, 2'b00);
    check("R2", "sel back to idle", sel, 3'b001);
    tick(1);
    check("R4", "lsEn drops after freewheel", {hsEn, lsEn}, 2'b00);
  endtask

  task automatic testZeroDead();
    deadCfg = 4'd0;
    tick(5);
    cmpRise(2'b00, 2'b10);
    tick(1);
    check("R4", "hsEn on", hsEn, 1'b1);
    cmpRise(2'b10, 2'b11);
    tick(1);
    check("R5", "zero dead acts as one gap", {hsEn, lsEn}, 2'b00);
    tick(1);
    check("R5", "lsEn on after one cycle", {hsEn, lsEn}, 2'b01);
    cmpRise(2'b11, 2'b00);
    deadCfg = 4'd3;
    tick(6);
  endtask

  task automatic testTimeout();
    tmoCfg = 8'd20;
    cmpRise(2'b00, 2'b10);
    tick(19);
    check("R6", "on-time before limit", phaseAB, 2'b10);
    check("R6", "no fault before limit", fault, 1'b0);
    tick(1);
    check("R6", "on-time timeout to idle", phaseAB, 2'b00);
    check("R6", "fault on on-time timeout", fault, 1'b1);
    tick(1);
    check("R6", "switches off after timeout", {hsEn, lsEn}, 2'b00);
    tick(4);
    check("R7", "fault held in idle", fault, 1'b1);
    cmpRise(2'b00, 2'b10);
    check("R7", "fault clears on new cycle", fault, 1'b0);
    cmpRise(2'b10, 2'b11);
    tick(19);
    check("R6", "freewheel before limit", phaseAB, 2'b11);
    tick(1);
    check("R6", "freewheel timeout to idle", phaseAB, 2'b00);
    check("R6", "fault on freewheel timeout", fault, 1'b1);
    tick(1);
    check("R6", "lsEn off after timeout", {hsEn, lsEn}, 2'b00);
    tick(4);
  endtask

  task automatic testNoTimeout();
    tmoCfg = 8'd0;
    cmpRise(2'b00, 2'b10);
    check("R7", "fault cleared", fault, 1'b0);
    tick(300);
    check("R6", "disabled timeout keeps on-time", phaseAB, 2'b10);
    check("R6", "disabled timeout no fault", fault, 1'b0);
    cmpRise(2'b10, 2'b11);
    cmpRise(2'b11, 2'b00);
    tick(4);
  endtask

  task automatic testHeldHigh();
    cmpDecision = 1'b1;
    tick(3);
    check("R3", "held high first advance", phaseAB, 2'b10);
    tick(20);
    check("R3", "held high no second advance", phaseAB, 2'b10);
    cmpRise(2'b10, 2'b11);
    cmpRise(2'b11, 2'b00);
    check("R2", "sel idle at end", sel, 3'b001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired act 1 exp 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testTrimIdle();
    testFullCycle();
    testZeroDead();
    testTimeout();
    testNoTimeout();
    testHeldHigh();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule